// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and resolves five hardware interrupt request lines into a single decision per clock. Each line has its own trigger rule. The non-maskable line needs a rising edge followed by a held level. The high-priority restart line is edge triggered and latched. The two lower restart lines and the general request line are level sensitive. When the block accepts a request it raises a one-cycle take strobe together with the 16-bit vector address the core should jump to.

The three restart lines can be masked individually through a small mask write port. A global enable gates every maskable source, and accepting any maskable source turns that enable off again. The general request line carries no vector of its own. Instead the block raises an acknowledge and waits until the requesting device supplies a restart number. Software restart instructions use the same restart-number-to-vector mapping and pass straight through. A status port shows the masks, the enable and the pending state of the restart lines.

Top module: `pvic_top`

## Requirements
- R1: Among recognized requests, the fixed priority is non-maskable > restart 7.5 > restart 6.5 > restart 5.5 > general line. The accepted line's vector is 0x0024, 0x003C, 0x0034 or 0x002C respectively. `take_o` is high for one cycle, the cycle after the clock edge at which the request was recognized, and `vec_o` is valid while `take_o` is high.
- R2: The non-maskable line is recognized only when a latched rising edge is still accompanied by a high level at a later clock edge. A one-cycle pulse is lost. The line is taken regardless of global enable and masks, is taken once per edge, and leaves the global enable unchanged.
- R3: A rising edge on restart 7.5 is latched and stays pending after the line falls. Servicing it clears the latch, and so does a mask write with `msk_wdata_i[3]`=1.
- R4: Restart 6.5, restart 5.5 and the general line are level sensitive. They are taken only while high and are not remembered once they fall.
- R5: A mask write loads `msk_wdata_i[2:0]` as the masks for 5.5 (bit 0), 6.5 (bit 1) and 7.5 (bit 2), where 1 means masked. After reset all three are masked. A masked line is never taken.
- R6: The global enable is 0 after reset. `en_set_i` sets it and `en_clr_i` clears it. Accepting any maskable source clears it, and that clear overrides a simultaneous set.
- R7: `status_o` bits [2:0] are the masks (5.5, 6.5, 7.5), bit 3 is the global enable, bit 4 is the 5.5 line level, bit 5 is the 6.5 line level, and bit 6 is the latched 7.5 pending state.
- R8: When the general line is accepted, `ack_o` rises and stays high with no take until `dev_valid_i`. On that cycle the block takes with vector `dev_num_i`×8 and drops `ack_o`.
- R9: While no acknowledge is outstanding, `sw_valid_i` produces a take with vector `sw_num_i`×8 (0x0000 to 0x0038). It wins over hardware requests in that cycle, leaves them pending, and does not change the global enable.
- R10: The 7.5 edge latch sets even while 7.5 is masked. Unmasking later causes the held request to be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req_i | input | 1 | Non-maskable request (edge and level) |
| r75_req_i | input | 1 | Restart 7.5 request (edge) |
| r65_req_i | input | 1 | Restart 6.5 request (level) |
| r55_req_i | input | 1 | Restart 5.5 request (level) |
| gen_req_i | input | 1 | General non-vectored request (level) |
| en_set_i | input | 1 | Set global enable |
| en_clr_i | input | 1 | Clear global enable |
| msk_wr_i | input | 1 | Mask write strobe |
| msk_wdata_i | input | 4 | Masks [2:0], 7.5 latch reset [3] |
| sw_valid_i | input | 1 | Software restart strobe |
| sw_num_i | input | 3 | Software restart number |
| dev_valid_i | input | 1 | Device restart number valid |
| dev_num_i | input | 3 | Device-supplied restart number |
| take_o | output | 1 | Take-interrupt strobe |
| vec_o | output | 16 | Vector address |
| ack_o | output | 1 | Acknowledge for general line |
| status_o | output | 7 | Mask, enable and pending status |

## Verification
On every cycle the assertions check several invariants. A recognized non-maskable request yields vector 0x0024 on the next cycle. A 6.5 take only follows an unmasked, enabled cycle. Every restart-line take leaves the enable cleared. The acknowledge wait holds with no take. The 7.5 latch does not drop on its own. The bench scenarios are needed to show how requests are ordered when several arrive together, that a short non-maskable pulse is lost, the mask-write latch reset, the device vector path and software precedence, because those depend on sequences of stimulus rather than on a single-cycle relation.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    localparam int NLINES = 5;
    localparam int L_NMI = 4;
    localparam int L_R75 = 3;
    localparam int L_R65 = 2;
    localparam int L_R55 = 1;
    localparam int L_GEN = 0;

    localparam logic [15:0] VEC_NMI = 16'h0024;
    localparam logic [15:0] VEC_R75 = 16'h003C;
    localparam logic [15:0] VEC_R65 = 16'h0034;
    localparam logic [15:0] VEC_R55 = 16'h002C;

    // indexed by line number; the general line has no fixed vector
    localparam logic [NLINES-1:0][15:0] LINE_VEC =
        {VEC_NMI, VEC_R75, VEC_R65, VEC_R55, 16'h0000};

    typedef enum logic {ST_IDLE, ST_ACK} pvic_st_e;
endpackage

// File: rtl/pvic_edge_latch.sv
module pvic_edge_latch #(
    parameter bit HOLD_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic lat;
    } el_t;

    el_t el_d, el_q;
    logic keep;

    always_comb begin
        el_d      = el_q;
        el_d.prev = req_i;
        keep      = el_q.lat & ~clr_i;
        if (HOLD_LEVEL) keep = keep & req_i;
        el_d.lat  = keep | (req_i & ~el_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) el_q <= '0;
        else        el_q <= el_d;
    end

    generate
        if (HOLD_LEVEL) begin : g_lvl
            assign pend_o = el_q.lat & req_i;
        end else begin : g_edge
            assign pend_o = el_q.lat;
            // R3: a latched edge stays pending until cleared
            a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_o && !clr_i) |=> pend_o);
        end
    endgenerate
endmodule

// File: rtl/pvic_prio_pick.sv
module pvic_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] cand_i,
    output logic [N-1:0] grant_o
);
    always_comb begin
        grant_o = '0;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i]) grant_o = N'(1) << i;
        end
    end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int VEC_W = 16,
    parameter int RST_W = 3,
    parameter int MSK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_req_i,
    input  logic             r75_req_i,
    input  logic             r65_req_i,
    input  logic             r55_req_i,
    input  logic             gen_req_i,
    input  logic             en_set_i,
    input  logic             en_clr_i,
    input  logic             msk_wr_i,
    input  logic [MSK_W-1:0] msk_wdata_i,
    input  logic             sw_valid_i,
    input  logic [RST_W-1:0] sw_num_i,
    input  logic             dev_valid_i,
    input  logic [RST_W-1:0] dev_num_i,
    output logic             take_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             ack_o,
    output logic [6:0]       status_o
);
    localparam int SPACE_SH = 3;
    localparam int NMASK    = MSK_W - 1;

    typedef struct packed {
        pvic_st_e         st;
        logic             ie;
        logic [NMASK-1:0] mask;
        logic             take;
        logic [VEC_W-1:0] vec;
        logic             ack;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic nmi_pend, r75_pend, nmi_clr, r75_clr;
    logic [NLINES-1:0] cand, grant;
    logic [VEC_W-1:0]  fixed_vec;

    pvic_edge_latch #(.HOLD_LEVEL(1'b1)) i_nmi_lat (
        .clk(clk), .rst_n(rst_n), .req_i(nmi_req_i), .clr_i(nmi_clr), .pend_o(nmi_pend)
    );

    pvic_edge_latch #(.HOLD_LEVEL(1'b0)) i_r75_lat (
        .clk(clk), .rst_n(rst_n), .req_i(r75_req_i), .clr_i(r75_clr), .pend_o(r75_pend)
    );

    always_comb begin
        cand        = '0;
        cand[L_NMI] = nmi_pend;
        cand[L_R75] = ctl_q.ie & ~ctl_q.mask[2] & r75_pend;
        cand[L_R65] = ctl_q.ie & ~ctl_q.mask[1] & r65_req_i;
        cand[L_R55] = ctl_q.ie & ~ctl_q.mask[0] & r55_req_i;
        cand[L_GEN] = ctl_q.ie & gen_req_i;
    end

    pvic_prio_pick #(.N(NLINES)) i_pick (.cand_i(cand), .grant_o(grant));

    always_comb begin
        fixed_vec = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (grant[i]) fixed_vec = VEC_W'(LINE_VEC[i]);
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.take = 1'b0;
        nmi_clr    = 1'b0;
        r75_clr    = 1'b0;

        if (en_set_i) ctl_d.ie = 1'b1;
        if (en_clr_i) ctl_d.ie = 1'b0;
        if (msk_wr_i) begin
            ctl_d.mask = msk_wdata_i[NMASK-1:0];
            r75_clr    = msk_wdata_i[NMASK];
        end

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (sw_valid_i) begin
                    ctl_d.take = 1'b1;
                    ctl_d.vec  = VEC_W'(sw_num_i) << SPACE_SH;
                end else if (grant[L_GEN]) begin
                    ctl_d.st  = ST_ACK;
                    ctl_d.ack = 1'b1;
                    ctl_d.ie  = 1'b0;
                end else if (|grant) begin
                    ctl_d.take = 1'b1;
                    ctl_d.vec  = fixed_vec;
                    if (grant[L_NMI]) begin
                        nmi_clr = 1'b1;
                    end else begin
                        ctl_d.ie = 1'b0;
                        if (grant[L_R75]) r75_clr = 1'b1;
                    end
                end
            end
            ST_ACK: begin
                if (dev_valid_i) begin
                    ctl_d.take = 1'b1;
                    ctl_d.vec  = VEC_W'(dev_num_i) << SPACE_SH;
                    ctl_d.ack  = 1'b0;
                    ctl_d.st   = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.mask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign take_o   = ctl_q.take;
    assign vec_o    = ctl_q.vec;
    assign ack_o    = ctl_q.ack;
    assign status_o = {r75_pend, r65_req_i, r55_req_i, ctl_q.ie, ctl_q.mask};

    a_r2_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && !sw_valid_i && nmi_pend)
        |=> (take_o && vec_o == VEC_W'(VEC_NMI)));

    a_r5_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o == VEC_W'(VEC_R65)) |-> $past(!ctl_q.mask[1] && ctl_q.ie));

    a_r6_enable_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (vec_o == VEC_W'(VEC_R75) || vec_o == VEC_W'(VEC_R65)
                    || vec_o == VEC_W'(VEC_R55))) |-> !ctl_q.ie);

    a_r8_ack_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ACK && !dev_valid_i) |=> (ack_o && !take_o));

    a_r8_ack_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !take_o);
endmodule

// File: tb/test_pvic_top.sv
module test_pvic_top;
    logic clk = 1'b0;
    logic rst_n;
    logic nmi, r75, r65, r55, gen, en_set, en_clr, msk_wr, sw_valid, dev_valid;
    logic [3:0]  msk_wdata;
    logic [2:0]  sw_num, dev_num;
    logic        take_o, ack_o;
    logic [15:0] vec_o;
    logic [6:0]  status_o;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    pvic_top i_pvic_top (
        .clk(clk), .rst_n(rst_n),
        .nmi_req_i(nmi), .r75_req_i(r75), .r65_req_i(r65), .r55_req_i(r55),
        .gen_req_i(gen), .en_set_i(en_set), .en_clr_i(en_clr),
        .msk_wr_i(msk_wr), .msk_wdata_i(msk_wdata),
        .sw_valid_i(sw_valid), .sw_num_i(sw_num),
        .dev_valid_i(dev_valid), .dev_num_i(dev_num),
        .take_o(take_o), .vec_o(vec_o), .ack_o(ack_o), .status_o(status_o)
    );

    // monitor: compare every take against the scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1 && take_o === 1'b1) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R1: unexpected take, actual vec=%h expected none", vec_o);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (vec_o !== e) begin
                    fails++;
                    $display("FAIL %s: vector actual=%h expected=%h", t, vec_o, e);
                end
            end
        end
    end

    task automatic expect_take(input logic [15:0] v, input string rq);
        exp_q.push_back(v);
        tag_q.push_back(rq);
    endtask

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string rq);
        cyc(4);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: missing takes actual=%0d expected=0", rq, exp_q.size());
        end
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic mask_write(input logic [3:0] w);
        msk_wr = 1'b1; msk_wdata = w;
        cyc(1);
        msk_wr = 1'b0;
    endtask

    task automatic enable();
        en_set = 1'b1;
        cyc(1);
        en_set = 1'b0;
    endtask

    task automatic sw_restart(input logic [2:0] n);
        sw_valid = 1'b1; sw_num = n;
        cyc(1);
        sw_valid = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        {nmi, r75, r65, r55, gen, en_set, en_clr, msk_wr, sw_valid, dev_valid} = '0;
        msk_wdata = '0; sw_num = '0; dev_num = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R5 R6 R7: reset state
        chk("R7 reset status", status_o, 7'h07);
        chk("R1 reset take", take_o, 0);
        chk("R8 reset ack", ack_o, 0);

        // R5 R7: mask readback
        mask_write(4'b0010);
        chk("R7 mask readback", status_o, 7'h02);
        enable();
        chk("R6 enable set", status_o, 7'h0A);
        en_clr = 1'b1; cyc(1); en_clr = 1'b0;
        chk("R6 enable clear", status_o, 7'h02);
        enable();
        mask_write(4'b0000);
        chk("R5 unmask all", status_o, 7'h08);

        // R1 R4: 6.5 beats 5.5 beats general
        expect_take(16'h0034, "R1 6.5 first");
        r65 = 1'b1; r55 = 1'b1; gen = 1'b1;
        cyc(3);
        chk("R6 enable cleared by take", status_o, 7'h30);
        r65 = 1'b0;
        drain("R1 6.5");
        gen = 1'b0;
        expect_take(16'h002C, "R1 5.5 next");
        enable();
        cyc(2);
        r55 = 1'b0;
        drain("R1 5.5");
        // R4: level lines forgotten once low
        enable();
        cyc(4);
        chk("R4 no stale level", status_o, 7'h08);

        // R1 R2: non-maskable over 7.5, enable untouched by nmi
        expect_take(16'h0024, "R1 nmi first");
        expect_take(16'h003C, "R1 7.5 after nmi");
        nmi = 1'b1; r75 = 1'b1;
        cyc(1);
        r75 = 1'b0;
        drain("R1 nmi/7.5");
        nmi = 1'b0;
        chk("R3 latch cleared by service", status_o, 7'h00);

        // R2: one-cycle pulse lost, held level taken once
        nmi = 1'b1; cyc(1); nmi = 1'b0;
        drain("R2 short pulse");
        expect_take(16'h0024, "R2 nmi held");
        nmi = 1'b1; cyc(6); nmi = 1'b0;
        drain("R2 held once");

        // R10 R3: latch while masked, reset by mask write
        mask_write(4'b0100);
        r75 = 1'b1; cyc(1); r75 = 1'b0;
        cyc(2);
        chk("R10 latched while masked", status_o, 7'h44);
        enable();
        cyc(3);
        mask_write(4'b1100);
        chk("R3 latch reset by write", status_o, 7'h0C);
        mask_write(4'b0000);
        drain("R3 no take after reset");
        chk("R3 enable still set", status_o, 7'h08);

        // R10: held edge taken on unmask
        mask_write(4'b0100);
        r75 = 1'b1; cyc(1); r75 = 1'b0;
        cyc(2);
        expect_take(16'h003C, "R10 take on unmask");
        mask_write(4'b0000);
        drain("R10 unmask");
        chk("R10 status after", status_o, 7'h00);

        // R8: acknowledge handshake for general line
        enable();
        gen = 1'b1;
        cyc(3);
        chk("R8 ack raised", ack_o, 1);
        cyc(2);
        chk("R8 ack held", ack_o, 1);
        expect_take(16'h0028, "R8 device vector");
        dev_valid = 1'b1; dev_num = 3'd5;
        cyc(1);
        dev_valid = 1'b0;
        chk("R8 ack dropped", ack_o, 0);
        gen = 1'b0;
        chk("R8 enable cleared", status_o, 7'h00);
        drain("R8");

        // R9: software restarts
        expect_take(16'h0018, "R9 sw 3");
        sw_restart(3'd3);
        expect_take(16'h0038, "R9 sw 7");
        sw_restart(3'd7);
        expect_take(16'h0000, "R9 sw 0");
        sw_restart(3'd0);
        drain("R9 sw");
        enable();
        expect_take(16'h0010, "R9 sw 2");
        sw_restart(3'd2);
        cyc(2);
        chk("R9 enable kept", status_o, 7'h08);
        expect_take(16'h0030, "R9 sw wins");
        expect_take(16'h0034, "R9 hw after sw");
        r65 = 1'b1; sw_valid = 1'b1; sw_num = 3'd6;
        cyc(1);
        sw_valid = 1'b0;
        cyc(3);
        r65 = 1'b0;
        drain("R9 precedence");

        summary();
    end
endmodule